// File: doc/BRIEF.md
# Gated BCD Pulse-Length Meter with Free-Running Count/Latch/Clear Sequencer

This block measures how long an external gate pulse stays high, in cycles of a reference clock. While the gate is high, a chain of cascaded decimal digit counters advances once per reference clock cycle. The final count is therefore the reference frequency multiplied by the gate duration. The gate is asynchronous to the reference clock, so it first passes through a two-flop synchronizer. Its falling edge is detected inside the reference clock domain.

A four-phase controller runs on its own. The falling edge of the synchronized gate ends the counting phase. The controller then passes through a hold phase, in which the result is copied into a display register, and a clear phase, in which every digit returns to zero. A one-cycle restart phase follows, after which counting resumes. The unit repeats its measurement indefinitely with no external control.

When the count would pass the largest value the chain can show, the counters stop at all nines and a sticky overflow flag is raised. The flag travels to the display together with the digits. The hold and clear durations are parameters given in reference clock cycles; their defaults are 5000 and 1000, which suit a 100 kHz reference.

Top module: `gate_timer_bcd`

## Requirements
- R1: The phase output uses the encoding COUNT=0, LATCH=1, CLEAR=2, RESTART=3. It is COUNT after reset and only ever steps to the next value in the order COUNT, LATCH, CLEAR, RESTART, COUNT.
- R2: The gate passes through two synchronizing flops. A falling edge of the synchronized gate seen while in COUNT moves the controller to LATCH. Gate activity in any other phase neither changes the phase timing nor alters the displayed result.
- R3: In COUNT, the digit chain increments once per clock cycle while the synchronized gate is high. A gate held high across N rising clock edges therefore yields a count of N.
- R4: Each digit is 4-bit BCD, with digit 0 (least significant) in bits [3:0] and digit k in bits [4k+3:4k]. A digit rolls over from 9 to 0 and carries into the next digit.
- R5: The display register and the displayed overflow flag load from the counters only while in LATCH. They hold their value in every other phase and read zero after reset.
- R6: LATCH lasts exactly HOLD_CYCLES clock cycles and CLEAR lasts exactly CLEAR_CYCLES clock cycles. During CLEAR every digit is forced to zero.
- R7: RESTART lasts exactly one clock cycle and is always followed by COUNT.
- R8: An increment requested while every digit is 9 leaves the digits at all nines and sets a sticky overflow flag. That flag is shown on the overflow output after LATCH and is cleared during CLEAR, so the next measurement starts without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Asynchronous gate pulse whose high time is measured |
| disp_o | output | 4*DIGITS | Latched BCD result, digit 0 in the low nibble |
| ovf_o | output | 1 | Latched overflow flag of the displayed result |
| phase_o | output | 2 | Current controller phase (0 COUNT, 1 LATCH, 2 CLEAR, 3 RESTART) |

## Verification
The bench sweeps the gate length from one cycle up past the saturation point of a two-digit chain. A design whose synchronizer or edge detector dropped or added a cycle would show an off-by-one count on every measurement. A broken carry would fail at 10 and 100. A counter that wrapped instead of saturating would show a small value, or no overflow flag, beyond 99. The sweep also measures the length of every phase, so a timer that ends one cycle early or late, or a restart that lingers, is caught. The bench raises the gate during LATCH and checks that this is ignored. It checks that the display stays frozen through the following count. It then runs a short measurement after an overflow, which exposes a flag that is not cleared.

// File: rtl/gtb_pkg.sv
package gtb_pkg;

    typedef enum logic [1:0] {
        PH_COUNT   = 2'd0,
        PH_LATCH   = 2'd1,
        PH_CLEAR   = 2'd2,
        PH_RESTART = 2'd3
    } phase_e;

    localparam int unsigned BCD_W = 4;
    localparam logic [BCD_W-1:0] BCD_MAX = 4'd9;

endpackage

// File: rtl/gtb_gate_sync.sv
module gtb_gate_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gate_i,
    output logic level_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = gate_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.s2;
    assign fall_o  = sync_q.prev & ~sync_q.s2;

endmodule

// File: rtl/gtb_bcd_digit.sv
module gtb_bcd_digit
    import gtb_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [BCD_W-1:0] q_o,
    output logic             carry_o
);
    typedef struct packed {
        logic [BCD_W-1:0] val;
    } digit_t;

    digit_t dig_d, dig_q;
    logic   at_max;

    assign at_max = (dig_q.val == BCD_MAX);

    always_comb begin
        dig_d = dig_q;
        if (clr_i) begin
            dig_d.val = '0;
        end else if (inc_i) begin
            dig_d.val = at_max ? '0 : dig_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dig_q <= '0;
        end else begin
            dig_q <= dig_d;
        end
    end

    assign q_o     = dig_q.val;
    assign carry_o = inc_i & at_max & ~clr_i;

endmodule

// File: rtl/gtb_phase_ctrl.sv
module gtb_phase_ctrl
    import gtb_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES  = 5000,
    parameter int unsigned CLEAR_CYCLES = 1000
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   fall_i,
    output phase_e phase_o
);
    localparam int unsigned LONGEST = (HOLD_CYCLES > CLEAR_CYCLES) ? HOLD_CYCLES : CLEAR_CYCLES;
    localparam int unsigned TW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [TW-1:0] HOLD_LAST  = TW'(HOLD_CYCLES - 1);
    localparam logic [TW-1:0] CLEAR_LAST = TW'(CLEAR_CYCLES - 1);

    typedef struct packed {
        phase_e        phase;
        logic [TW-1:0] tmr;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.phase)
            PH_COUNT: begin
                if (fall_i) begin
                    ctrl_d.phase = PH_LATCH;
                    ctrl_d.tmr   = '0;
                end
            end
            PH_LATCH: begin
                if (ctrl_q.tmr == HOLD_LAST) begin
                    ctrl_d.phase = PH_CLEAR;
                    ctrl_d.tmr   = '0;
                end else begin
                    ctrl_d.tmr = ctrl_q.tmr + 1'b1;
                end
            end
            PH_CLEAR: begin
                if (ctrl_q.tmr == CLEAR_LAST) begin
                    ctrl_d.phase = PH_RESTART;
                    ctrl_d.tmr   = '0;
                end else begin
                    ctrl_d.tmr = ctrl_q.tmr + 1'b1;
                end
            end
            PH_RESTART: begin
                ctrl_d.phase = PH_COUNT;
                ctrl_d.tmr   = '0;
            end
            default: begin
                ctrl_d.phase = PH_COUNT;
                ctrl_d.tmr   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q.phase <= PH_COUNT;
            ctrl_q.tmr   <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign phase_o = ctrl_q.phase;

endmodule

// File: rtl/gate_timer_bcd.sv
module gate_timer_bcd
    import gtb_pkg::*;
#(
    parameter int unsigned DIGITS       = 4,
    parameter int unsigned HOLD_CYCLES  = 5000,
    parameter int unsigned CLEAR_CYCLES = 1000
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  gate_i,
    output logic [4*DIGITS-1:0]   disp_o,
    output logic                  ovf_o,
    output logic [1:0]            phase_o
);
    localparam int unsigned CW = BCD_W * DIGITS;

    typedef struct packed {
        logic [CW-1:0] disp;
        logic          disp_ovf;
        logic          ovf;
    } core_t;

    core_t core_d, core_q;

    logic          gate_lvl;
    logic          gate_fall;
    phase_e        phase;
    logic [CW-1:0] cnt_q;
    logic [DIGITS:0] carry;
    logic [DIGITS-1:0] nine;
    logic          all_nines;
    logic          count_en;
    logic          clr_cnt;

    gtb_gate_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .gate_i  (gate_i),
        .level_o (gate_lvl),
        .fall_o  (gate_fall)
    );

    gtb_phase_ctrl #(
        .HOLD_CYCLES  (HOLD_CYCLES),
        .CLEAR_CYCLES (CLEAR_CYCLES)
    ) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fall_i  (gate_fall),
        .phase_o (phase)
    );

    assign count_en  = (phase == PH_COUNT) & gate_lvl;
    assign clr_cnt   = (phase == PH_CLEAR);
    assign all_nines = &nine;
    assign carry[0]  = count_en & ~all_nines;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        gtb_bcd_digit u_digit (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (clr_cnt),
            .inc_i   (carry[i]),
            .q_o     (cnt_q[BCD_W*i +: BCD_W]),
            .carry_o (carry[i+1])
        );
        assign nine[i] = (cnt_q[BCD_W*i +: BCD_W] == BCD_MAX);
    end

    always_comb begin
        core_d = core_q;
        if (clr_cnt) begin
            core_d.ovf = 1'b0;
        end else if (count_en && all_nines) begin
            core_d.ovf = 1'b1;
        end
        if (phase == PH_LATCH) begin
            core_d.disp     = cnt_q;
            core_d.disp_ovf = core_q.ovf;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign disp_o  = core_q.disp;
    assign ovf_o   = core_q.disp_ovf;
    assign phase_o = phase;

endmodule

// File: rtl/gate_timer_bcd_chk.sv
module gate_timer_bcd_chk #(
    parameter int unsigned DIGITS = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [1:0]          phase,
    input logic [4*DIGITS-1:0] disp,
    input logic [4*DIGITS-1:0] cnt,
    input logic                ovf_int
);
    a_r1_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase != $past(phase)) |-> (phase == $past(phase) + 2'd1));

    a_r7_restart_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == 2'd3) |=> (phase == 2'd0));

    a_r5_disp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase != 2'd1) |=> $stable(disp));

    a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == 2'd2) |=> (cnt == '0));

    a_r8_ovf_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == 2'd2) |=> !ovf_int);

    a_r8_ovf_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_int && phase == 2'd0) |-> (cnt == {DIGITS{4'd9}}));

    for (genvar i = 0; i < DIGITS; i++) begin : g_bcd
        a_r4_digit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cnt[4*i +: 4] <= 4'd9);
    end

endmodule

bind gate_timer_bcd gate_timer_bcd_chk #(.DIGITS(DIGITS)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase   (phase_o),
    .disp    (disp_o),
    .cnt     (cnt_q),
    .ovf_int (core_q.ovf)
);

// File: tb/gate_timer_bcd_tb.sv
module gate_timer_bcd_tb;
    localparam int unsigned DIG   = 2;
    localparam int unsigned HOLD  = 6;
    localparam int unsigned CLR   = 4;
    localparam int          LIMIT = 99;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              gate = 1'b0;
    logic [4*DIG-1:0]  disp;
    logic              ovf;
    logic [1:0]        phase;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    gate_timer_bcd #(
        .DIGITS       (DIG),
        .HOLD_CYCLES  (HOLD),
        .CLEAR_CYCLES (CLR)
    ) u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .gate_i  (gate),
        .disp_o  (disp),
        .ovf_o   (ovf),
        .phase_o (phase)
    );

    function automatic logic [4*DIG-1:0] to_bcd(int v);
        logic [4*DIG-1:0] r = '0;
        int x = v;
        for (int i = 0; i < DIG; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(int g, bit poke);
        logic [4*DIG-1:0] held;
        int n;
        int exp;
        n = 0;
        while (phase != 2'd0 && n < 100) begin
            @(negedge clk);
            n++;
        end
        held = disp;
        @(negedge clk);
        gate = 1'b1;
        repeat (g) @(negedge clk);
        check(disp == held, "R5 display held in COUNT", int'(disp), int'(held));
        gate = 1'b0;
        n = 0;
        while (phase == 2'd0 && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(phase == 2'd1, "R2 falling gate enters LATCH", int'(phase), 1);
        n = 0;
        while (phase == 2'd1 && n < int'(HOLD) + 5) begin
            if (poke && n == 1) gate = 1'b1;
            if (poke && n == 3) gate = 1'b0;
            @(negedge clk);
            n++;
        end
        check(n == int'(HOLD), "R6 LATCH length", n, HOLD);
        exp = (g > LIMIT) ? LIMIT : g;
        check(disp == to_bcd(exp), "R3 R4 latched BCD count", int'(disp), int'(to_bcd(exp)));
        check(ovf == (g > LIMIT), "R8 overflow flag", int'(ovf), int'(g > LIMIT));
        n = 0;
        while (phase == 2'd2 && n < int'(CLR) + 5) begin
            @(negedge clk);
            n++;
        end
        check(n == int'(CLR), "R6 CLEAR length", n, CLR);
        n = 0;
        while (phase == 2'd3 && n < 5) begin
            @(negedge clk);
            n++;
        end
        check(n == 1, "R7 RESTART length", n, 1);
        check(phase == 2'd0, "R1 back to COUNT", int'(phase), 0);
        check(disp == to_bcd(exp), "R5 display held after LATCH", int'(disp), int'(to_bcd(exp)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 R5: reset state
        check(phase == 2'd0, "R1 reset phase", int'(phase), 0);
        check(disp == '0, "R5 reset display", int'(disp), 0);
        check(ovf == 1'b0, "R5 reset overflow", int'(ovf), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(phase == 2'd0, "R1 idle in COUNT without gate", int'(phase), 0);
        for (int g = 1; g <= 110; g++) begin
            measure(g, 1'b0);
        end
        // R8: overflow cleared for the next measurement
        measure(7, 1'b0);
        measure(LIMIT, 1'b0);
        measure(LIMIT + 1, 1'b0);
        measure(3, 1'b0);
        // R2: gate activity during LATCH ignored
        measure(42, 1'b1);
        measure(10, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule